// File: doc/BRIEF.md
# Sequence-Locked Watchdog Timer

This block is a memory-mapped watchdog. An upward counter advances on ticks of a slow timebase, optionally divided by a power-of-two prescaler. When the counter steps past all-ones while the watchdog is armed, the block raises a reset request for one clock cycle and restarts the count from a programmed load value. Software keeps the system alive by writing the trigger register with a value different from the previous one, which reloads the counter before it can overflow.

The block is driven through a simple register bus with a word address, write data, a write strobe and combinational read data. Writes to the control, load, trigger and arm registers are posted. Each one is held in a staging register and takes effect on the second slow tick after the bus write. A status register shows which posted writes have not taken effect yet. Arming and disarming each need a two-word unlock sequence on the arm register, so a single stray write cannot change the enable state.

Register word addresses: 0 revision, 1 control, 2 status, 3 load, 4 trigger, 5 arm, 6 count (read-only). Writes to read-only addresses are ignored.

Top module: `wdt_seq`

## Requirements
- R1: The watchdog becomes armed when the arm register applies 0x0000BBBB and the next word it applies is 0x00004444.
- R2: The watchdog becomes disarmed when the arm register applies 0x0000AAAA and the next word it applies is 0x00005555.
- R3: Any other order of applied arm words leaves the armed state unchanged. This includes a correct second word that follows a different word.
- R4: While armed with the prescaler disabled, the count rises by one on every slow tick. While disarmed, it holds its value.
- R5: In the control register, bit 5 enables the prescaler and bits 4:2 hold an exponent r. When the prescaler is enabled, the count rises once per 2^r ticks. When it is disabled, r is ignored.
- R6: An applied trigger write reloads the count from the load register only if its value differs from the previously applied trigger value (which is 0 after reset). An equal value has no effect.
- R7: When an armed count step goes from all-ones, the reset output is high for exactly one cycle and the count becomes the load value.
- R8: Status bits 0, 2, 3 and 4 flag pending writes to the control, load, trigger and arm registers. Each bit sets after the bus write and clears when the write takes effect, on the second tick after it.
- R9: After reset, the status, count and reset output are zero. Bits 7:0 of the revision register read the REV parameter, its upper bits read zero, and writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per slow timebase period |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| wdt_rst_o | output | 1 | Reset request, one cycle per overflow |

## Verification
A posted write takes effect on the clock edge of the second tick after its bus write. The matching status bit reads set after the write cycle and after the first tick, and reads clear only after the second tick. The count changes at the same edge as the tick that steps it, and the reset output rises at that edge and falls one cycle later. The bench therefore drives every tick as a one-cycle pulse and samples the count and the reset output at the falling edge straight after it. A bench-side model advances the expected count per tick and applies each posted effect only after the second tick, using the state from before that tick. This matches how the counter steps in the same cycle an arm or disarm word lands.

// File: rtl/wdt_seq_pkg.sv
package wdt_seq_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int NCH    = 4;
    localparam int POST_DELAY = 2;

    localparam logic [ADDR_W-1:0] A_REV   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TRIG  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ARM   = 3'd5;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd6;

    // posted channel indices
    localparam int CH_CTRL = 0;
    localparam int CH_LOAD = 1;
    localparam int CH_TRIG = 2;
    localparam int CH_ARM  = 3;

    localparam logic [DATA_W-1:0] ARM_KEY1    = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] ARM_KEY2    = 32'h0000_4444;
    localparam logic [DATA_W-1:0] DISARM_KEY1 = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] DISARM_KEY2 = 32'h0000_5555;

    localparam int CTL_EN_BIT  = 5;
    localparam int CTL_EXP_LSB = 2;
    localparam int EXP_W       = 3;

    function automatic logic [ADDR_W-1:0] ch_addr(input int idx);
        case (idx)
            CH_CTRL: ch_addr = A_CTRL;
            CH_LOAD: ch_addr = A_LOAD;
            CH_TRIG: ch_addr = A_TRIG;
            default: ch_addr = A_ARM;
        endcase
    endfunction

    typedef struct packed {
        logic              armed;
        logic [DATA_W-1:0] last_arm;
        logic [DATA_W-1:0] last_trig;
        logic [DATA_W-1:0] ctl;
    } ctl_state_t;

endpackage

// File: rtl/wdt_seq_post.sv
module wdt_seq_post
    import wdt_seq_pkg::*;
#(
    parameter int DELAY = POST_DELAY
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              pend_o,
    output logic              apply_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CW = $clog2(DELAY + 1);

    typedef struct packed {
        logic              pend;
        logic [CW-1:0]     ticks;
        logic [DATA_W-1:0] data;
    } post_t;

    post_t s_d, s_q;
    logic  apply;

    always_comb begin
        s_d   = s_q;
        apply = 1'b0;
        if (wr_i) begin
            s_d.pend  = 1'b1;
            s_d.ticks = '0;
            s_d.data  = wdata_i;
        end else if (s_q.pend && tick_i) begin
            if (s_q.ticks == CW'(DELAY - 1)) begin
                s_d.pend = 1'b0;
                apply    = 1'b1;
            end else begin
                s_d.ticks = s_q.ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pend_o  = s_q.pend;
    assign apply_o = apply;
    assign data_o  = s_q.data;

    p_pend_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> s_q.pend);
    p_pend_clear_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(s_q.pend) |-> $past(tick_i));

endmodule

// File: rtl/wdt_seq_prescale.sv
module wdt_seq_prescale
    import wdt_seq_pkg::*;
#(
    parameter int EW = EXP_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          clear_i,
    input  logic          en_i,
    input  logic [EW-1:0] exp_i,
    output logic          step_o
);
    localparam int PW = (1 << EW) - 1;

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW:0]   span;
    logic          step;

    always_comb begin
        span  = ((PW + 1)'(1) << exp_i) - 1'b1;
        step  = run_i && tick_i && (!en_i || ({1'b0, cnt_q} >= span));
        cnt_d = cnt_q;
        if (!run_i || clear_i || !en_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = step ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign step_o = step;

    p_step_needs_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |-> (tick_i && run_i));

endmodule

// File: rtl/wdt_seq_counter.sv
module wdt_seq_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] count_d, count_q;
    logic             wrap_d, wrap_q;

    always_comb begin
        count_d = count_q;
        wrap_d  = 1'b0;
        if (reload_i) begin
            count_d = load_i;
        end else if (step_i) begin
            if (&count_q) begin
                count_d = load_i;
                wrap_d  = 1'b1;
            end else begin
                count_d = count_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
            wrap_q  <= 1'b0;
        end else begin
            count_q <= count_d;
            wrap_q  <= wrap_d;
        end
    end

    assign count_o = count_q;
    assign wrap_o  = wrap_q;

    p_wrap_from_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_q |-> ($past(&count_q) && count_q == $past(load_i)));
    p_hold_without_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(step_i) && !$past(reload_i)) |-> $stable(count_q));

endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
    import wdt_seq_pkg::*;
#(
    parameter int          CNT_W = 32,
    parameter logic [7:0]  REV   = 8'h21
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              wdt_rst_o
);
    logic [NCH-1:0]    ch_wr, ch_pend, ch_apply;
    logic [DATA_W-1:0] ch_data [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_post
        assign ch_wr[i] = wr_i && (addr_i == ch_addr(i));
        wdt_seq_post #(.DELAY(POST_DELAY)) u_post (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (tick_i),
            .wr_i    (ch_wr[i]),
            .wdata_i (wdata_i),
            .pend_o  (ch_pend[i]),
            .apply_o (ch_apply[i]),
            .data_o  (ch_data[i])
        );
    end

    ctl_state_t       st_d, st_q;
    logic [CNT_W-1:0] load_d, load_q;
    logic             reload;
    logic             step;
    logic [CNT_W-1:0] count;

    always_comb begin
        st_d   = st_q;
        load_d = load_q;
        reload = 1'b0;
        if (ch_apply[CH_CTRL]) st_d.ctl = ch_data[CH_CTRL];
        if (ch_apply[CH_LOAD]) load_d = ch_data[CH_LOAD][CNT_W-1:0];
        if (ch_apply[CH_TRIG]) begin
            reload         = (ch_data[CH_TRIG] != st_q.last_trig);
            st_d.last_trig = ch_data[CH_TRIG];
        end
        if (ch_apply[CH_ARM]) begin
            if (st_q.last_arm == ARM_KEY1 && ch_data[CH_ARM] == ARM_KEY2)
                st_d.armed = 1'b1;
            if (st_q.last_arm == DISARM_KEY1 && ch_data[CH_ARM] == DISARM_KEY2)
                st_d.armed = 1'b0;
            st_d.last_arm = ch_data[CH_ARM];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= '0;
            load_q <= '0;
        end else begin
            st_q   <= st_d;
            load_q <= load_d;
        end
    end

    wdt_seq_prescale #(.EW(EXP_W)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .run_i   (st_q.armed),
        .clear_i (ch_apply[CH_CTRL]),
        .en_i    (st_q.ctl[CTL_EN_BIT]),
        .exp_i   (st_q.ctl[CTL_EXP_LSB +: EXP_W]),
        .step_o  (step)
    );

    wdt_seq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step),
        .reload_i (reload),
        .load_i   (load_d),
        .count_o  (count),
        .wrap_o   (wdt_rst_o)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_REV:   rdata_o = {24'h0, REV};
            A_CTRL:  rdata_o = st_q.ctl;
            A_STAT:  rdata_o = {27'h0, ch_pend[CH_ARM], ch_pend[CH_TRIG],
                                ch_pend[CH_LOAD], 1'b0, ch_pend[CH_CTRL]};
            A_LOAD:  rdata_o = DATA_W'(load_q);
            A_TRIG:  rdata_o = st_q.last_trig;
            A_ARM:   rdata_o = st_q.last_arm;
            A_COUNT: rdata_o = DATA_W'(count);
            default: rdata_o = '0;
        endcase
    end

    p_arm_sequence_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.armed) |-> ($past(ch_apply[CH_ARM]) &&
                               $past(ch_data[CH_ARM]) == ARM_KEY2 &&
                               $past(st_q.last_arm) == ARM_KEY1));
    p_disarm_sequence_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.armed) |-> ($past(ch_apply[CH_ARM]) &&
                               $past(ch_data[CH_ARM]) == DISARM_KEY2 &&
                               $past(st_q.last_arm) == DISARM_KEY1));
    p_arm_only_by_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.armed) |-> $past(ch_apply[CH_ARM]));
    p_reset_only_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_o |-> $past(st_q.armed));

endmodule

// File: tb/wdt_seq_tb_top.sv
module wdt_seq_tb_top;
    localparam int CW = 8;
    localparam logic [7:0] REVV = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic        wrst;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the count path (prescaler off)
    logic         m_armed = 1'b0;
    logic [CW-1:0] m_cnt = '0;
    logic [CW-1:0] m_load = '0;
    logic         m_track = 1'b1;
    int           n_wraps = 0;

    always #5 clk = ~clk;

    wdt_seq #(.CNT_W(CW), .REV(REVV)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
        .wdata_i(wdata), .wr_i(wr), .rdata_o(rdata), .wdt_rst_o(wrst)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // one tick; model steps with pre-tick state, R7 checked every tick
    task automatic do_tick();
        logic exp_wrap;
        exp_wrap = 1'b0;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (m_track && m_armed) begin
            if (&m_cnt) begin m_cnt = m_load; exp_wrap = 1'b1; end
            else m_cnt = m_cnt + 1'b1;
        end
        check("R7 reset pulse at tick", {31'h0, wrst}, {31'h0, exp_wrap});
        if (wrst) begin
            n_wraps++;
            @(negedge clk);
            check("R7 reset pulse one cycle", {31'h0, wrst}, 32'h0);
        end
    endtask

    task automatic check_count(input string req);
        logic [31:0] v;
        rd(3'd6, v);
        check(req, v, {24'h0, m_cnt});
    endtask

    // posted write: one tick, then the applying tick; model effect after it
    logic [31:0] m_last_arm = '0;
    logic [31:0] m_last_trig = '0;
    task automatic post(input logic [2:0] a, input logic [31:0] d);
        bus_wr(a, d);
        do_tick();
        do_tick();
        case (a)
            3'd3: m_load = d[CW-1:0];
            3'd4: begin
                if (d != m_last_trig) m_cnt = m_load;
                m_last_trig = d;
            end
            3'd5: begin
                if (m_last_arm == 32'hBBBB && d == 32'h4444) m_armed = 1'b1;
                if (m_last_arm == 32'hAAAA && d == 32'h5555) m_armed = 1'b0;
                m_last_arm = d;
            end
            default: ;
        endcase
    endtask

    task automatic pend_sweep(input logic [2:0] a, input logic [31:0] d, input logic [31:0] bitv);
        logic [31:0] v;
        bus_wr(a, d);
        rd(3'd2, v); check("R8 pending after write", v, bitv);
        do_tick();
        rd(3'd2, v); check("R8 pending after first tick", v, bitv);
        do_tick();
        rd(3'd2, v); check("R8 cleared after second tick", v, 32'h0);
        case (a)
            3'd3: m_load = d[CW-1:0];
            3'd4: begin if (d != m_last_trig) m_cnt = m_load; m_last_trig = d; end
            3'd5: m_last_arm = d;
            default: ;
        endcase
    endtask

    initial begin : watchdog
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state and revision
        rd(3'd0, v); check("R9 revision", v, {24'h0, REVV});
        rd(3'd2, v); check("R9 status reset", v, 32'h0);
        rd(3'd6, v); check("R9 count reset", v, 32'h0);
        check("R9 reset output", {31'h0, wrst}, 32'h0);
        bus_wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R9 revision write ignored", v, {24'h0, REVV});

        // R8 pending flags per register, bit positions 0,2,3,4
        pend_sweep(3'd1, 32'h0, 32'h01);
        pend_sweep(3'd3, 32'hF0, 32'h04);
        pend_sweep(3'd4, 32'h1, 32'h08);
        check_count("R6 differing trigger reloads");
        pend_sweep(3'd5, 32'hBBBB, 32'h10);

        // R1 arm
        post(3'd5, 32'h4444);
        check_count("R1 no step on arming tick");
        do_tick();
        check_count("R1/R4 armed counts");
        check("R4 count value", {24'h0, m_cnt}, 32'hF1);

        // R4 and R7: run through several overflows
        for (int i = 0; i < 50; i++) do_tick();
        check_count("R7 count after wraps");
        check("R7 wrap count", n_wraps, 3);

        // R6 equal trigger ignored, differing reloads
        post(3'd4, 32'h1);
        check_count("R6 equal trigger ignored");
        post(3'd4, 32'hFFFF_FFFE);
        check_count("R6 new trigger reloads");
        check("R6 reloaded value", {24'h0, m_cnt}, 32'hF0);

        // R2 disarm
        post(3'd5, 32'hAAAA);
        post(3'd5, 32'h5555);
        check("R2 model disarmed", {31'h0, m_armed}, 32'h0);
        c0 = {24'h0, m_cnt};
        do_tick(); do_tick();
        check_count("R2/R4 disarmed holds");
        check("R4 hold value", {24'h0, m_cnt}, c0);

        // R3 broken sequences
        post(3'd5, 32'hBBBB);
        post(3'd5, 32'h1234);
        post(3'd5, 32'h4444);
        do_tick();
        check_count("R3 interrupted arm ignored");
        post(3'd4, 32'h2);
        post(3'd5, 32'hBBBB);
        post(3'd5, 32'h4444);
        post(3'd5, 32'hAAAA);
        post(3'd5, 32'h4444);
        post(3'd5, 32'h5555);
        do_tick();
        check_count("R3 interrupted disarm ignored");
        check("R3 still armed", {31'h0, m_armed}, 32'h1);

        // R5 prescaler sweep
        post(3'd3, 32'h0);
        post(3'd4, 32'h3);
        m_track = 1'b0;
        for (int r = 0; r < 8; r++) begin
            bus_wr(3'd1, 32'h20 | (r << 2));
            do_tick(); do_tick();
            rd(3'd6, c0);
            for (int k = 0; k < 2 * (1 << r) - 1; k++) do_tick();
            rd(3'd6, v); check($sformatf("R5 exp %0d before step", r), v, c0 + 1);
            do_tick();
            rd(3'd6, v); check($sformatf("R5 exp %0d at step", r), v, c0 + 2);
        end
        bus_wr(3'd1, 32'h14);
        do_tick(); do_tick();
        rd(3'd6, c0);
        do_tick(); do_tick(); do_tick();
        rd(3'd6, v); check("R5 disabled ignores exponent", v, c0 + 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule